// File: doc/BRIEF.md
# Retriggerable Compare Pulse Generator

This block watches an externally generated free-running counter and compares it with one compare value per channel. When an enabled channel's comparison becomes true, that channel's output goes high for a programmed time. The time is an 8-bit width count multiplied by a time base of 2^N clock periods, where N is a 3-bit prescaler selection (divide by 1 up to 128).

All channels share one width timer. Any new trigger, on either channel, reloads the width count and restarts the prescaler divider. Every channel whose pulse is still high stays high until the reloaded count expires. As a result, when triggers overlap, the earlier channel's pulse is stretched and the latest channel's pulse has exactly the programmed width. When triggers do not overlap, each channel produces an independent pulse of exact width. Counter generation and bus access sit outside the block.

Top module: `cmp_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every `pulse_out` bit is low after that edge. After reset is released, outputs stay low until a new trigger occurs.
- R2: A trigger on channel i is a cycle in which `ch_en[i]` is 1 and `cnt_val` equals the channel's compare value (channel i uses bits `[16*i+15:16*i]` of `cmp_vals`), while the same condition was false in the previous cycle. With a nonzero width, `pulse_out[i]` is high after the clock edge that ends the trigger cycle. An output never rises without a trigger.
- R3: An isolated pulse stays high for exactly `pw_len << prsc_sel` clock cycles, for every `prsc_sel` from 0 to 7 and every `pw_len` from 1 to 255.
- R4: A trigger while `pw_len` is 0 produces no pulse.
- R5: If the counter holds at the compare value for several cycles, only one trigger occurs, and the pulse width is unchanged.
- R6: A second trigger on the same channel during its pulse (or in its last high cycle) reloads the timer, so the pulse ends `pw_len << prsc_sel` cycles after the edge that follows the second trigger.
- R7: If one channel triggers while the other channel's pulse is high, the earlier pulse is extended and both outputs fall on the same edge. The later pulse has exactly the programmed width.
- R8: Triggers that fall outside each other's pulses give independent pulses of exact width.
- R9: Triggers on both channels in the same cycle give two pulses of exact width that fall together.
- R10: When `ch_en[i]` is 0 at a clock edge, `pulse_out[i]` is low after that edge. Matches on a disabled channel start no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Current counter value |
| cmp_vals | input | 32 | Compare values, channel 0 in the low 16 bits |
| ch_en | input | 2 | Per-channel enable for the pulse mode |
| pw_len | input | 8 | Pulse width in time-base units |
| prsc_sel | input | 3 | Time base is 2^prsc_sel clock periods |
| pulse_out | output | 2 | Registered pulse outputs |

## Verification
The assertions check these properties on every cycle: clearing by reset and by a dropped enable, that a pulse starts on the edge after a trigger, that no output rises without a trigger or with a zero width, and that two running pulses end on the same edge. Exact pulse lengths depend on a long count and on the order of triggers, so only the bench's scenarios can show them. The bench sweeps the prescaler and width values and places the two channels' triggers at many offsets (retrigger, overlap, disjoint, simultaneous). For each sample it compares the outputs against high intervals computed from the trigger times.

// File: rtl/cmp_pulse_pkg.sv
// Package: shared constants and helpers for the compare pulse generator.
// Assumes: prescaler selections are small (3 bits) so the divider fits in
// 2^PRSC_W - 1 bits.
package cmp_pulse_pkg;

    localparam int DEF_CNT_W  = 16;
    localparam int DEF_PW_W   = 8;
    localparam int DEF_PRSC_W = 3;
    localparam int DEF_NUM_CH = 2;

    // Divider width that holds the largest terminal count for a prescaler field.
    function automatic int div_width(input int prsc_w);
        return (1 << prsc_w) - 1;
    endfunction

endpackage

// File: rtl/cmp_match_edge.sv
// Module: detects the rising edge of one channel's enabled equality condition.
// Assumes: cnt and cmp are stable within a cycle; reset is synchronous active-low.
module cmp_match_edge #(
    parameter int CNT_W = cmp_pulse_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             trig
);

    logic eq_now;
    logic eq_prev;

    // Combinational equality qualified by the channel enable.
    always_comb begin
        eq_now = en && (cnt == cmp);
    end

    // Remember last cycle's condition so a held match fires once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_prev <= 1'b0;
        end else begin
            eq_prev <= eq_now;
        end
    end

    // Trigger on the first cycle of the condition only.
    always_comb begin
        trig = eq_now && !eq_prev;
    end

endmodule

// File: rtl/cmp_width_timer.sv
// Module: shared retriggerable width timer with a power-of-two prescaler.
// On load it captures the width and restarts the divider; it then decrements
// once per 2^prsc clocks and flags the final clock of the running interval.
// Assumes: load is only asserted with a nonzero width.
module cmp_width_timer #(
    parameter int PW_W   = cmp_pulse_pkg::DEF_PW_W,
    parameter int PRSC_W = cmp_pulse_pkg::DEF_PRSC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PW_W-1:0]   width,
    input  logic [PRSC_W-1:0] prsc,
    output logic              last_tick
);

    localparam int DIV_W = cmp_pulse_pkg::div_width(PRSC_W);

    logic [PW_W-1:0]  remain;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;
    logic             unit_done;

    // Terminal divider count for the selected prescaler (2^prsc - 1).
    always_comb begin
        div_lim   = (DIV_W'(1) << prsc) - DIV_W'(1);
        unit_done = (div_cnt >= div_lim);
    end

    // Width countdown and divider; a load restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            div_cnt <= '0;
        end else if (load) begin
            remain  <= width;
            div_cnt <= '0;
        end else if (remain != '0) begin
            if (unit_done) begin
                div_cnt <= '0;
                remain  <= remain - PW_W'(1);
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    // Final clock of the interval: last unit and its last divider step.
    always_comb begin
        last_tick = (remain == PW_W'(1)) && unit_done;
    end

endmodule

// File: rtl/cmp_pulse_chan.sv
// Module: one channel's registered pulse output.
// Sets on a qualified trigger, clears when the shared timer expires or the
// channel enable is low. Assumes end_tick is already suppressed on reloads.
module cmp_pulse_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic end_tick,
    output logic pulse
);

    // Output register with enable forcing, start priority over end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else if (!en) begin
            pulse <= 1'b0;
        end else if (start) begin
            pulse <= 1'b1;
        end else if (end_tick) begin
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/cmp_pulse_gen.sv
// Module: top of the retriggerable compare pulse generator.
// Per channel it detects compare-match edges. One shared timer sets the
// pulse length, and any trigger reloads it and stretches running pulses.
// Assumes: the counter is driven externally and all inputs are synchronous to clk.
module cmp_pulse_gen #(
    parameter int NUM_CH = cmp_pulse_pkg::DEF_NUM_CH,
    parameter int CNT_W  = cmp_pulse_pkg::DEF_CNT_W,
    parameter int PW_W   = cmp_pulse_pkg::DEF_PW_W,
    parameter int PRSC_W = cmp_pulse_pkg::DEF_PRSC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        cnt_val,
    input  logic [NUM_CH*CNT_W-1:0] cmp_vals,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [PW_W-1:0]         pw_len,
    input  logic [PRSC_W-1:0]       prsc_sel,
    output logic [NUM_CH-1:0]       pulse_out
);

    logic [NUM_CH-1:0] trig;
    logic              width_nz;
    logic              load;
    logic              last_tick;
    logic              end_tick;

    // Per-channel match edge detection and output register.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        cmp_match_edge #(
            .CNT_W(CNT_W)
        ) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (ch_en[ch]),
            .cnt  (cnt_val),
            .cmp  (cmp_vals[ch*CNT_W +: CNT_W]),
            .trig (trig[ch])
        );

        cmp_pulse_chan u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ch_en[ch]),
            .start   (trig[ch] && width_nz),
            .end_tick(end_tick),
            .pulse   (pulse_out[ch])
        );
    end

    // Shared reload: any trigger with a nonzero width; reload cancels expiry.
    always_comb begin
        width_nz = (pw_len != '0);
        load     = (|trig) && width_nz;
        end_tick = last_tick && !load;
    end

    cmp_width_timer #(
        .PW_W  (PW_W),
        .PRSC_W(PRSC_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .width    (pw_len),
        .prsc     (prsc_sel),
        .last_tick(last_tick)
    );

endmodule

// File: rtl/cmp_pulse_gen_chk.sv
// Checker: port-level properties of the compare pulse generator, bound to the top.
// Tracks its own copy of the previous match condition to recognise triggers.
module cmp_pulse_gen_chk #(
    parameter int NUM_CH = cmp_pulse_pkg::DEF_NUM_CH,
    parameter int CNT_W  = cmp_pulse_pkg::DEF_CNT_W,
    parameter int PW_W   = cmp_pulse_pkg::DEF_PW_W,
    parameter int PRSC_W = cmp_pulse_pkg::DEF_PRSC_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CNT_W-1:0]        cnt_val,
    input logic [NUM_CH*CNT_W-1:0] cmp_vals,
    input logic [NUM_CH-1:0]       ch_en,
    input logic [PW_W-1:0]         pw_len,
    input logic [PRSC_W-1:0]       prsc_sel,
    input logic [NUM_CH-1:0]       pulse_out
);

    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] hit_q;
    logic [NUM_CH-1:0] fire;

    // Enabled equality per channel as seen at the ports.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            hit[i] = ch_en[i] && (cnt_val == cmp_vals[i*CNT_W +: CNT_W]);
        end
        fire = hit & ~hit_q & {NUM_CH{pw_len != '0}};
    end

    // Previous-cycle match history for edge recognition.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= hit;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (pulse_out == '0)); // R1

    AST_ZERO_WIDTH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_len == '0 && pulse_out == '0) |=> (pulse_out == '0)); // R4

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |=> !pulse_out[i]); // R10

        AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> pulse_out[i]); // R2

        AST_NO_FALSE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            (!pulse_out[i] && !fire[i]) |=> !pulse_out[i]); // R2
    end

    if (NUM_CH >= 2) begin : g_pair
        AST_SHARED_END: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_out[0] && pulse_out[1] && ch_en[0] && ch_en[1] && fire == '0)
            |=> (pulse_out[0] == pulse_out[1])); // R7
    end

endmodule

bind cmp_pulse_gen cmp_pulse_gen_chk #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W),
    .PW_W  (PW_W),
    .PRSC_W(PRSC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_val  (cnt_val),
    .cmp_vals (cmp_vals),
    .ch_en    (ch_en),
    .pw_len   (pw_len),
    .prsc_sel (prsc_sel),
    .pulse_out(pulse_out)
);

// File: tb/sim_cmp_pulse_gen.sv
module sim_cmp_pulse_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_val;
    logic [31:0] cmp_vals;
    logic [1:0]  ch_en;
    logic [7:0]  pw_len;
    logic [2:0]  prsc_sel;
    logic [1:0]  pulse_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cmp_pulse_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .cmp_vals (cmp_vals),
        .ch_en    (ch_en),
        .pw_len   (pw_len),
        .prsc_sel (prsc_sel),
        .pulse_out(pulse_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One scenario: channel 0 matches at ta (held hold cycles) and again at ta2,
    // channel 1 matches at tb (-1 = none). Expected high intervals come from
    // trigger times: every trigger sets end = t + W, active channels stay high
    // through the sample at end.
    task automatic scen(input int ta, input int ta2, input int tb, input int pw,
                        input int p, input int hold, input string req);
        int w, window, tend, last;
        bit act0, act1, prev0, prev1;
        int hi0, hi1, ex0, ex1, mis0, mis1, rise0, rise1;
        logic [15:0] cb;
        w = pw << p;
        cb = (ta == tb) ? 16'd10 : 16'd20;
        cmp_vals = {cb, 16'd10};
        pw_len = 8'(pw);
        prsc_sel = 3'(p);
        ch_en = 2'b11;
        last = ta;
        if (ta2 > last) last = ta2;
        if (tb > last) last = tb;
        window = last + w + 4;
        tend = -1; act0 = 0; act1 = 0; prev0 = 0; prev1 = 0;
        hi0 = 0; hi1 = 0; ex0 = 0; ex1 = 0; mis0 = 0; mis1 = 0;
        rise0 = -1; rise1 = -1;
        for (int c = 0; c <= window; c++) begin
            bit m0, m1, t0, t1;
            @(negedge clk);
            // sample c reflects the edge ending cycle c-1
            if (pulse_out[0]) begin hi0++; if (rise0 < 0) rise0 = c; end
            if (pulse_out[1]) begin hi1++; if (rise1 < 0) rise1 = c; end
            if (pulse_out[0] != act0) mis0++;
            if (pulse_out[1] != act1) mis1++;
            if (act0) ex0++;
            if (act1) ex1++;
            // drive cycle c
            m0 = (ta >= 0 && c >= ta && c < ta + hold) || (c == ta2);
            m1 = (tb >= 0 && c == tb);
            if (m0)      cnt_val = 16'd10;
            else if (m1) cnt_val = cb;
            else         cnt_val = 16'd0;
            m0 = (cnt_val == 16'd10);
            m1 = (cnt_val == cb);
            t0 = m0 && !prev0;
            t1 = m1 && !prev1;
            prev0 = m0; prev1 = m1;
            if ((t0 || t1) && w > 0) begin
                tend = c + w;
                if (t0) act0 = 1;
                if (t1) act1 = 1;
            end
            if (c + 1 > tend) begin act0 = 0; act1 = 0; end
        end
        chk({req, " ch0 high count"}, hi0, ex0);
        chk({req, " ch1 high count"}, hi1, ex1);
        chk({req, " ch0 mismatched samples"}, mis0, 0);
        chk({req, " ch1 mismatched samples"}, mis1, 0);
        if (ta >= 0) chk({req, " ch0 first high sample"}, rise0, (w > 0) ? ta + 1 : -1);
        if (tb >= 0) chk({req, " ch1 first high sample"}, rise1, (w > 0) ? tb + 1 : -1);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int hcnt;
        rst_n = 1'b0;
        cnt_val = 16'd0;
        cmp_vals = {16'd10, 16'd10};
        ch_en = 2'b11;
        pw_len = 8'd5;
        prsc_sel = 3'd0;
        // R1: matches during reset produce nothing
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 outputs low in reset", int'(pulse_out), 0);
            cnt_val = (i % 2 == 0) ? 16'd10 : 16'd0;
        end
        @(negedge clk); cnt_val = 16'd0;
        @(negedge clk); rst_n = 1'b1;
        hcnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pulse_out != 2'b00) hcnt++;
        end
        chk("R1 outputs low after reset release", hcnt, 0);

        // R3: every prescaler with a small width, then widths with divide by 2
        for (int p = 0; p < 8; p++) scen(2, -1, -1, 3, p, 1, "R3 prescaler sweep");
        for (int pw = 0; pw <= 16; pw++)
            scen(2, -1, -1, pw, 1, 1, (pw == 0) ? "R4 zero width" : "R3 width sweep");
        scen(2, -1, 5, 0, 0, 1, "R4 zero width both channels");
        scen(2, -1, -1, 255, 7, 1, "R3 maximum width");
        // R5: counter held on compare value
        scen(2, -1, -1, 4, 1, 2, "R5 held match");
        scen(2, -1, -1, 4, 1, 5, "R5 held match");
        scen(2, -1, -1, 4, 1, 11, "R5 held match past pulse end");
        // R6: retrigger on the same channel at several offsets
        for (int k = 2; k <= 8; k++) scen(2, 2 + k, -1, 3, 1, 1, "R6 same-channel retrigger");
        // R7 / R8: other channel at offsets inside and outside the pulse
        for (int k = 1; k <= 9; k++)
            scen(2, -1, 2 + k, 3, 1, 1, (k < 7) ? "R7 overlapping channels" : "R8 disjoint channels");
        scen(7, -1, 2, 2, 2, 1, "R7 channel 1 first");
        scen(2, -1, 20, 4, 0, 1, "R8 disjoint channels");
        // R9: same-cycle triggers
        scen(2, -1, 2, 5, 0, 1, "R9 simultaneous triggers");
        scen(2, -1, 2, 3, 2, 1, "R9 simultaneous triggers");

        // R10: dropping enable mid-pulse clears the output on the next edge
        cmp_vals = {16'd20, 16'd10};
        pw_len = 8'd10; prsc_sel = 3'd0; ch_en = 2'b11;
        @(negedge clk); cnt_val = 16'd10;
        @(negedge clk); cnt_val = 16'd0;
        chk("R2 pulse high after trigger", int'(pulse_out[0]), 1);
        @(negedge clk); ch_en[0] = 1'b0;
        @(negedge clk);
        chk("R10 output low after enable drop", int'(pulse_out[0]), 0);
        ch_en[0] = 1'b1;
        hcnt = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (pulse_out[0]) hcnt++;
        end
        chk("R10 no restart on re-enable without match", hcnt, 0);
        // R10: match on a disabled channel is ignored
        ch_en = 2'b10;
        @(negedge clk); cnt_val = 16'd10;
        @(negedge clk); cnt_val = 16'd0;
        hcnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pulse_out != 2'b00) hcnt++;
        end
        chk("R10 disabled channel ignores match", hcnt, 0);
        ch_en = 2'b11;

        // R1: reset in the middle of a pulse clears it for good
        pw_len = 8'd50;
        @(negedge clk); cnt_val = 16'd10;
        @(negedge clk); cnt_val = 16'd0;
        @(negedge clk); @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset clears running pulse", int'(pulse_out), 0);
        hcnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pulse_out != 2'b00) hcnt++;
        end
        chk("R1 timer cleared by reset", hcnt, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule